// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a host into a serial bit stream. A one-entry holding buffer sits in front of a shift register. The host can therefore queue the next byte while the current frame is still being sent. When that byte is already waiting as a frame ends, it follows the last stop bit with no gap. A one-cycle bit tick, produced by an external rate generator, paces every bit. Nothing on the line moves between ticks.

There are two framing modes. Asynchronous mode sends a low start bit, then five to eight data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Synchronous master mode sends exactly eight data bits, most or least significant bit first, together with a generated shift clock that rests low between frames.

Two status outputs report progress to the host. One says the buffer is free to accept a byte. The other says the line has gone idle with nothing left to send. A further output asks the shared pad to drive when the transmitter runs in single-wire mode.

Top module: `dual_mode_tx`

## Requirements
- R1: After reset and whenever no frame is active, serOut is 1, sclkOut is 0, dataEmpty is 1 and txDone is 0 until a frame completes.
- R2: A wrStrobe is accepted only while dataEmpty is 1. Accepting it captures wrData and drives dataEmpty to 0 on the next cycle. A wrStrobe while dataEmpty is 0 is ignored, and the buffered byte is not replaced.
- R3: The buffer moves into the shift register only on an active tick (bitTick=1 with txEnable=1). This happens either while the shifter is idle or on the tick that ends the last stop bit or last SPI clock phase. dataEmpty returns to 1 right after that tick.
- R4: In asynchronous mode (cfgSpiMode=0), a frame starts with a 0 start bit. The data bits follow with the least significant bit first. A cfgDataLen value k gives k+5 data bits. Each bit lasts from one active tick to the next.
- R5: With cfgParityEn=1, a parity bit follows the data bits. With cfgParityOdd=0 (even), it is 1 when the number of 1 data bits is odd. With cfgParityOdd=1 (odd), it is 1 when that number is even.
- R6: The stop section is one high bit when cfgTwoStop=0 and two high bits when cfgTwoStop=1.
- R7: If the buffer is full when the final stop bit ends, the next frame's start bit begins on that same tick, and txDone stays 0.
- R8: txDone goes to 1 when a frame ends with the buffer empty. It stays 1 until txDoneClr=1 or until a write is accepted. An accepted write takes precedence over a frame ending in the same cycle, which takes precedence over txDoneClr.
- R9: In SPI mode (cfgSpiMode=1), a frame is 8 data bits. Each bit occupies two tick intervals: first sclkOut=0 with the new data on serOut, then sclkOut=1 with the data held. With cfgMsbFirst=1, bit 7 goes first; with cfgMsbFirst=0, bit 0 goes first. serOut and sclkOut change only on active ticks.
- R10: The mode, length, parity, stop and bit-order settings are sampled when a byte is loaded into the shift register. Changing them during a frame has no effect on that frame.
- R11: While txEnable is 0, bitTick is ignored. No frame starts, and the line and shift clock hold their values.
- R12: pinDriveEn is 1 exactly when txEnable=1 and cfgOneWire=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable |
| cfgOneWire | input | 1 | Single shared pad for send and receive |
| cfgSpiMode | input | 1 | 1 selects synchronous master framing |
| cfgMsbFirst | input | 1 | SPI bit order, 1 = most significant bit first |
| cfgDataLen | input | 2 | Asynchronous data length code (k+5 bits) |
| cfgParityEn | input | 1 | Append parity bit |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even |
| cfgTwoStop | input | 1 | Two stop bits |
| bitTick | input | 1 | One-cycle bit-rate pulse |
| wrStrobe | input | 1 | Host write request |
| wrData | input | 8 | Host write byte |
| txDoneClr | input | 1 | Clear transmit-complete flag |
| dataEmpty | output | 1 | Buffer can accept a byte |
| txDone | output | 1 | Transmit complete |
| serOut | output | 1 | Serial data line |
| sclkOut | output | 1 | Generated shift clock (SPI mode) |
| pinDriveEn | output | 1 | Output enable for the shared pad |

## Verification
The bench builds the block with its defaults: an 8-bit buffer, a 2-bit length code and a minimum length of 5. These values reach every asynchronous length, including both edges, 5 and 8 bits, and also the full SPI byte. The bench paces the line with hand-placed ticks, so it can insert a write between the first and last bit of a frame. This covers the zero-gap handoff, the rejected second write and mid-frame configuration changes, and checks the exact bit on the line after every tick.

// File: rtl/dmtx_pkg.sv
package dmtx_pkg;

  // line source selected by the control path
  typedef enum logic [2:0] {
    OUT_IDLE   = 3'd0,
    OUT_START  = 3'd1,
    OUT_DATA   = 3'd2,
    OUT_PARITY = 3'd3,
    OUT_STOP   = 3'd4
  } outSel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP1  = 3'd4,
    ST_STOP2  = 3'd5,
    ST_SPI_LO = 3'd6,
    ST_SPI_HI = 3'd7
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    shift;
    outSel_e outSel;
  } txStrobe_t;

endpackage

// File: rtl/dmtx_datapath.sv
module dmtx_datapath
  import dmtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  input  logic              cfgSpiMode,
  input  logic              cfgMsbFirst,
  input  logic              cfgParityOdd,
  input  logic [LEN_W-1:0]  cfgDataLen,
  output logic              bufValid,
  output logic              wrAccept,
  output logic              serOut
);

  logic [DATA_W-1:0] bufData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parityBit;
  logic              msbFirstQ;
  logic              curBit;

  assign wrAccept = wrStrobe & ~bufValid;

  // data bits that take part in parity for the selected length
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (i < (MIN_LEN + int'(cfgDataLen)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid  <= 1'b0;
      bufData   <= '0;
    end else if (wrAccept) begin
      bufValid  <= 1'b1;
      bufData   <= wrData;
    end else if (strobe.load) begin
      bufValid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      msbFirstQ <= 1'b0;
    end else if (strobe.load) begin
      shiftReg  <= bufData;
      parityBit <= (^(bufData & lenMask)) ^ cfgParityOdd;
      msbFirstQ <= cfgSpiMode & cfgMsbFirst;
    end else if (strobe.shift) begin
      if (msbFirstQ) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      else           shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  assign curBit = msbFirstQ ? shiftReg[DATA_W-1] : shiftReg[0];

  always_comb begin
    unique case (strobe.outSel)
      OUT_START:  serOut = 1'b0;
      OUT_DATA:   serOut = curBit;
      OUT_PARITY: serOut = parityBit;
      default:    serOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/dmtx_ctrl.sv
module dmtx_ctrl
  import dmtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             txEnable,
  input  logic             bufValid,
  input  logic             wrAccept,
  input  logic             txDoneClr,
  input  logic             cfgSpiMode,
  input  logic [LEN_W-1:0] cfgDataLen,
  input  logic             cfgParityEn,
  input  logic             cfgTwoStop,
  output txStrobe_t        strobe,
  output logic             sclkOut,
  output logic             txDone
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] SPI_LAST = CNT_W'(DATA_W - 1);

  txState_e         state, nextState;
  logic [CNT_W-1:0] bitIdx, nextIdx;
  logic [CNT_W-1:0] lastIdxQ;
  logic             parEnQ, twoStopQ;
  logic             tickEn, load, shift, frameEnd;

  assign tickEn = bitTick & txEnable;

  always_comb begin
    nextState = state;
    nextIdx   = bitIdx;
    load      = 1'b0;
    shift     = 1'b0;
    frameEnd  = 1'b0;
    if (tickEn) begin
      unique case (state)
        ST_IDLE:   load = bufValid;
        ST_START:  nextState = ST_DATA;
        ST_DATA: begin
          if (bitIdx == lastIdxQ) begin
            nextState = parEnQ ? ST_PARITY : ST_STOP1;
          end else begin
            shift   = 1'b1;
            nextIdx = bitIdx + 1'b1;
          end
        end
        ST_PARITY: nextState = ST_STOP1;
        ST_STOP1: begin
          if (twoStopQ) nextState = ST_STOP2;
          else          frameEnd  = 1'b1;
        end
        ST_STOP2:  frameEnd = 1'b1;
        ST_SPI_LO: nextState = ST_SPI_HI;
        ST_SPI_HI: begin
          if (bitIdx == SPI_LAST) begin
            frameEnd = 1'b1;
          end else begin
            shift     = 1'b1;
            nextIdx   = bitIdx + 1'b1;
            nextState = ST_SPI_LO;
          end
        end
        default:   nextState = ST_IDLE;
      endcase
      if (frameEnd) begin
        load      = bufValid;
        nextState = ST_IDLE;
      end
      if (load) begin
        nextState = cfgSpiMode ? ST_SPI_LO : ST_START;
        nextIdx   = '0;
        shift     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      lastIdxQ <= '0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else begin
      state  <= nextState;
      bitIdx <= nextIdx;
      if (load) begin
        lastIdxQ <= CNT_W'(MIN_LEN - 1) + CNT_W'(cfgDataLen);
        parEnQ   <= cfgParityEn;
        twoStopQ <= cfgTwoStop;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      txDone <= 1'b0;
    else if (wrAccept)              txDone <= 1'b0;
    else if (frameEnd && !bufValid) txDone <= 1'b1;
    else if (txDoneClr)             txDone <= 1'b0;
  end

  always_comb begin
    unique case (state)
      ST_START:                      strobe.outSel = OUT_START;
      ST_DATA, ST_SPI_LO, ST_SPI_HI: strobe.outSel = OUT_DATA;
      ST_PARITY:                     strobe.outSel = OUT_PARITY;
      ST_STOP1, ST_STOP2:            strobe.outSel = OUT_STOP;
      default:                       strobe.outSel = OUT_IDLE;
    endcase
  end

  assign strobe.load  = load;
  assign strobe.shift = shift;
  assign sclkOut      = (state == ST_SPI_HI);

endmodule

// File: rtl/dual_mode_tx.sv
module dual_mode_tx
  import dmtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              cfgOneWire,
  input  logic              cfgSpiMode,
  input  logic              cfgMsbFirst,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              bitTick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txDoneClr,
  output logic              dataEmpty,
  output logic              txDone,
  output logic              serOut,
  output logic              sclkOut,
  output logic              pinDriveEn
);

  txStrobe_t strobe;
  logic      bufValid;
  logic      wrAccept;

  dmtx_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .bitTick     (bitTick),
    .txEnable    (txEnable),
    .bufValid    (bufValid),
    .wrAccept    (wrAccept),
    .txDoneClr   (txDoneClr),
    .cfgSpiMode  (cfgSpiMode),
    .cfgDataLen  (cfgDataLen),
    .cfgParityEn (cfgParityEn),
    .cfgTwoStop  (cfgTwoStop),
    .strobe      (strobe),
    .sclkOut     (sclkOut),
    .txDone      (txDone)
  );

  dmtx_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrStrobe     (wrStrobe),
    .wrData       (wrData),
    .strobe       (strobe),
    .cfgSpiMode   (cfgSpiMode),
    .cfgMsbFirst  (cfgMsbFirst),
    .cfgParityOdd (cfgParityOdd),
    .cfgDataLen   (cfgDataLen),
    .bufValid     (bufValid),
    .wrAccept     (wrAccept),
    .serOut       (serOut)
  );

  assign dataEmpty  = ~bufValid;
  assign pinDriveEn = txEnable & cfgOneWire;

endmodule

// File: rtl/dual_mode_tx_chk.sv
module dual_mode_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic bitTick,
  input logic wrStrobe,
  input logic dataEmpty,
  input logic txDone,
  input logic serOut,
  input logic sclkOut
);

  assert_write_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !dataEmpty && !(bitTick && txEnable)) |=> !dataEmpty);

  assert_drain_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEmpty) |-> $past(bitTick && txEnable));

  assert_line_paced_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $past(bitTick && txEnable));

  assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> (dataEmpty && $past(bitTick && txEnable)));

  assert_sclk_paced_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkOut) |-> $past(bitTick && txEnable));

endmodule

bind dual_mode_tx dual_mode_tx_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .txEnable  (txEnable),
  .bitTick   (bitTick),
  .wrStrobe  (wrStrobe),
  .dataEmpty (dataEmpty),
  .txDone    (txDone),
  .serOut    (serOut),
  .sclkOut   (sclkOut)
);

// File: tb/dual_mode_tx_tb_top.sv
module dual_mode_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b1;
  logic       cfgOneWire = 1'b0;
  logic       cfgSpiMode = 1'b0;
  logic       cfgMsbFirst = 1'b0;
  logic [1:0] cfgDataLen = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic       bitTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txDoneClr = 1'b0;
  logic       dataEmpty, txDone, serOut, sclkOut, pinDriveEn;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_mode_tx dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .cfgOneWire(cfgOneWire),
    .cfgSpiMode(cfgSpiMode), .cfgMsbFirst(cfgMsbFirst), .cfgDataLen(cfgDataLen),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .bitTick(bitTick), .wrStrobe(wrStrobe), .wrData(wrData), .txDoneClr(txDoneClr),
    .dataEmpty(dataEmpty), .txDone(txDone), .serOut(serOut), .sclkOut(sclkOut),
    .pinDriveEn(pinDriveEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk) begin wrStrobe = 1'b1; wrData = d; end
    @(negedge clk) wrStrobe = 1'b0;
  endtask

  function automatic void buildAsync(input logic [7:0] d, input int lenCode,
                                     input bit parEn, input bit odd, input bit twoStop,
                                     output logic [15:0] fb, output int n);
    int len = lenCode + 5;
    logic p = odd;
    fb = '1;
    fb[0] = 1'b0;
    for (int i = 0; i < len; i++) begin
      fb[1+i] = d[i];
      p ^= d[i];
    end
    n = 1 + len;
    if (parEn) begin fb[n] = p; n++; end
    n += twoStop ? 2 : 1;
  endfunction

  task automatic checkBits(input logic [15:0] fb, input int from, input int n, input string req);
    for (int i = from; i < n; i++) begin
      tickOnce();
      chk(req, serOut, fb[i]);
    end
  endtask

  task automatic setAsync(input int lenCode, input bit parEn, input bit odd, input bit twoStop);
    cfgSpiMode = 1'b0; cfgDataLen = lenCode[1:0];
    cfgParityEn = parEn; cfgParityOdd = odd; cfgTwoStop = twoStop;
  endtask

  task automatic finishFrame(input string req);
    tickOnce();
    chk(req, txDone, 1'b1);
    chk("R1 idle line", serOut, 1'b1);
    chk("R3 empty after frame", dataEmpty, 1'b1);
  endtask

  task automatic testReset();
    chk("R1 serOut", serOut, 1'b1);
    chk("R1 sclkOut", sclkOut, 1'b0);
    chk("R1 dataEmpty", dataEmpty, 1'b1);
    chk("R1 txDone", txDone, 1'b0);
  endtask

  task automatic runAsync(input logic [7:0] d, input int lenCode, input bit parEn,
                          input bit odd, input bit twoStop, input string req);
    logic [15:0] fb; int n;
    setAsync(lenCode, parEn, odd, twoStop);
    buildAsync(d, lenCode, parEn, odd, twoStop, fb, n);
    writeByte(d);
    chk("R2 buffer full after write", dataEmpty, 1'b0);
    chk("R8 write clears done", txDone, 1'b0);
    tickOnce();
    chk({req, " start"}, serOut, fb[0]);
    chk("R3 loaded on tick", dataEmpty, 1'b1);
    checkBits(fb, 1, n, req);
    finishFrame("R8 done after frame");
  endtask

  task automatic testBackToBack();
    logic [15:0] fa, fbB; int na, nb;
    setAsync(3, 1'b0, 1'b0, 1'b0);
    buildAsync(8'h3C, 3, 1'b0, 1'b0, 1'b0, fa, na);
    buildAsync(8'hC5, 3, 1'b0, 1'b0, 1'b0, fbB, nb);
    writeByte(8'h3C);
    tickOnce();
    chk("R7 first start", serOut, 1'b0);
    writeByte(8'hC5);
    chk("R2 second write accepted", dataEmpty, 1'b0);
    checkBits(fa, 1, na, "R7 first frame");
    tickOnce();
    chk("R7 next start at stop end", serOut, 1'b0);
    chk("R7 no done between frames", txDone, 1'b0);
    chk("R3 reload empties buffer", dataEmpty, 1'b1);
    checkBits(fbB, 1, nb, "R7 second frame");
    finishFrame("R8 done after second frame");
  endtask

  task automatic testIgnoredWrite();
    logic [15:0] fb; int n;
    setAsync(3, 1'b0, 1'b0, 1'b0);
    buildAsync(8'h0F, 3, 1'b0, 1'b0, 1'b0, fb, n);
    writeByte(8'h0F);
    writeByte(8'hF0);
    chk("R2 still full", dataEmpty, 1'b0);
    checkBits(fb, 0, n, "R2 first byte kept");
    finishFrame("R2 dropped byte not sent");
  endtask

  task automatic testDoneClear();
    chk("R8 done held", txDone, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 done sticky", txDone, 1'b1);
    txDoneClr = 1'b1;
    @(negedge clk) txDoneClr = 1'b0;
    chk("R8 cleared by txDoneClr", txDone, 1'b0);
  endtask

  task automatic runSpi(input logic [7:0] d, input bit msb);
    cfgSpiMode = 1'b1; cfgMsbFirst = msb;
    writeByte(d);
    for (int b = 0; b < 8; b++) begin
      logic exp = msb ? d[7-b] : d[b];
      tickOnce();
      chk("R9 sclk low phase", sclkOut, 1'b0);
      chk("R9 data low phase", serOut, exp);
      tickOnce();
      chk("R9 sclk high phase", sclkOut, 1'b1);
      chk("R9 data high phase", serOut, exp);
    end
    tickOnce();
    chk("R9 sclk idles low", sclkOut, 1'b0);
    chk("R9 line idles high", serOut, 1'b1);
    chk("R8 done after SPI frame", txDone, 1'b1);
    cfgSpiMode = 1'b0; cfgMsbFirst = 1'b0;
  endtask

  task automatic testCfgMidFrame();
    logic [15:0] fb; int n;
    setAsync(3, 1'b0, 1'b0, 1'b0);
    buildAsync(8'h81, 3, 1'b0, 1'b0, 1'b0, fb, n);
    writeByte(8'h81);
    tickOnce();
    chk("R10 start", serOut, 1'b0);
    cfgDataLen = 2'd0; cfgParityEn = 1'b1; cfgParityOdd = 1'b1;
    cfgTwoStop = 1'b1; cfgMsbFirst = 1'b1;
    checkBits(fb, 1, n, "R10 frame unchanged");
    finishFrame("R10 frame length unchanged");
    setAsync(3, 1'b0, 1'b0, 1'b0); cfgMsbFirst = 1'b0;
  endtask

  task automatic testEnable();
    logic [15:0] fb; int n;
    setAsync(3, 1'b0, 1'b0, 1'b0);
    buildAsync(8'h55, 3, 1'b0, 1'b0, 1'b0, fb, n);
    txEnable = 1'b0;
    writeByte(8'h55);
    tickOnce();
    chk("R11 no start while disabled", serOut, 1'b1);
    chk("R11 buffer kept", dataEmpty, 1'b0);
    txEnable = 1'b1;
    tickOnce();
    chk("R11 start after enable", serOut, 1'b0);
    txEnable = 1'b0;
    tickOnce();
    chk("R11 start bit held", serOut, 1'b0);
    txEnable = 1'b1;
    checkBits(fb, 1, n, "R11 frame after pause");
    finishFrame("R11 done");
  endtask

  task automatic testOneWire();
    cfgOneWire = 1'b1; txEnable = 1'b0; #1;
    chk("R12 disabled", pinDriveEn, 1'b0);
    txEnable = 1'b1; #1;
    chk("R12 enabled one-wire", pinDriveEn, 1'b1);
    cfgOneWire = 1'b0; #1;
    chk("R12 two-wire", pinDriveEn, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runAsync(8'hA5, 3, 1'b0, 1'b0, 1'b0, "R4 eight bits");
    runAsync(8'h3F, 0, 1'b0, 1'b0, 1'b0, "R4 five bits");
    runAsync(8'h07, 3, 1'b1, 1'b0, 1'b0, "R5 even parity");
    runAsync(8'h07, 3, 1'b1, 1'b1, 1'b1, "R5 R6 odd parity two stop");
    runAsync(8'h1A, 1, 1'b1, 1'b1, 1'b0, "R5 six bits odd");
    runAsync(8'h66, 2, 1'b0, 1'b0, 1'b1, "R6 two stop");
    testDoneClear();
    testBackToBack();
    testIgnoredWrite();
    runSpi(8'hB2, 1'b1);
    runSpi(8'hB2, 1'b0);
    testCfgMidFrame();
    testEnable();
    testOneWire();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule